// File: doc/BRIEF.md
# CAN Message Slot Request Controller

This block holds the control and status flags of a single CAN message slot that can be set to transmit or to receive. It takes host register writes on one side and event strobes from the protocol engine on the other. The engine reports three events: a matching remote frame was seen, a data frame was received and stored, and a transmission finished successfully. From these inputs the block keeps five flags: host transmit request, external request, data-fresh, overwrite and inhibit. It also drives two eligibility levels that tell the engine whether the slot may send a data frame or a remote frame now.

One bit position of the control register has two meanings, chosen by the slot direction. In receive direction it is a read-only overwrite flag. In transmit direction it is a read/write transmit inhibit. The host request flag can only be set by the host, never cleared by it. A remote request is answered automatically only when the data is fresh and the slot is not inhibited.

Register map: address 0 is the control register, with data-fresh at bit 0, overwrite/inhibit at bit 1, host request at bit 2 and external request at bit 3. Address 1 is the configuration register, with direction at bit 0 (1 = transmit) and overwrite-enable at bit 1. Reads are combinational and return zero in unused bits.

Top module: `can_slot_req_ctrl`

## Requirements
- R1: After reset both registers read 0, and sendData and sendRemote are 0.
- R2: A remote event sets the external request flag (control bit 3) in either direction. In transmit direction the same event also sets the host request flag (bit 2).
- R3: While the external request is pending in transmit direction, sendData is 1 only if data-fresh (bit 0) is 1 and inhibit is 0.
- R4: A success event in transmit direction clears bits 2 and 3. In receive direction it clears bit 2 and leaves bit 3 unchanged. A host write of 0 to bit 3 clears it, and a write of 1 to bit 3 has no effect.
- R5: A host write of 1 to bit 2 sets it. A host write of 0 to bit 2 leaves it unchanged.
- R6: softRst clears bit 2 on the next edge. It takes priority over a host write of 1 in the same cycle.
- R7: With bit 2 set and no external request, sendData is 1 in transmit direction when inhibit is 0. In receive direction sendRemote is 1 instead.
- R8: In receive direction a store event sets bit 0. If bit 0 was already 1 and overwrite-enable is 1, the store also sets the overwrite flag (bit 1). A store event in transmit direction has no effect.
- R9: A host write of 0 to bit 0 clears both bit 0 and the overwrite flag.
- R10: In receive direction, with overwrite-enable 0 and bit 0 already 1, a store event changes nothing and the overwrite flag stays 0.
- R11: Inhibit can only be written while the direction is transmit. While inhibit is 1, no data frame is eligible, but remote requests are still recorded. Writing inhibit to 0 releases the pending reply.
- R12: If inhibit is left at 1 and the slot is switched to receive with overwrite-enable 1, bit 1 reads 1. With overwrite-enable 0 it reads the overwrite flag.
- R13: A success event and a host write of 1 to bit 2 in the same cycle leave bit 2 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low system reset |
| softRst | input | 1 | Controller soft reset; clears the host request |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Write address (0 control, 1 configuration) |
| wrData | input | REG_W | Write data |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | REG_W | Combinational read data |
| evRemote | input | 1 | Matching remote frame seen |
| evStore | input | 1 | Data frame received and stored |
| evTxDone | input | 1 | Transmission completed successfully |
| sendData | output | 1 | Slot eligible to send a data frame |
| sendRemote | output | 1 | Slot eligible to send a remote frame |

## Verification
The host request flag can be set by a host write and cleared by a success event in the same cycle. The bench drives both in one cycle and expects bit 2 to remain 1. It also drives a host write of 1 together with softRst and expects the soft reset to win. The remaining scenarios each move the slot through one direction change or one event sequence, and read both registers back through the read port.

// File: rtl/can_slot_pkg.sv
package can_slot_pkg;
  localparam int FRESH_BIT = 0;
  localparam int SHARE_BIT = 1;
  localparam int HREQ_BIT  = 2;
  localparam int XREQ_BIT  = 3;
  localparam int DIR_BIT   = 0;
  localparam int OVEN_BIT  = 1;
  localparam int CTRL_ADDR = 0;
  localparam int CFG_ADDR  = 1;

  typedef struct packed {
    logic loadCfg;
    logic dirVal;
    logic ovEnVal;
    logic loadFresh;
    logic freshVal;
    logic setOvr;
    logic clrOvr;
    logic loadInh;
    logic inhVal;
    logic killHreq;
    logic setHreq;
    logic clrHreq;
    logic setXreq;
    logic clrXreq;
  } slotStrobe_t;

  typedef struct packed {
    logic dir;
    logic ovEn;
    logic fresh;
    logic ovr;
    logic inh;
    logic hreq;
    logic xreq;
  } slotState_t;
endpackage

// File: rtl/can_slot_ctrl.sv
module can_slot_ctrl
  import can_slot_pkg::*;
#(
  parameter int REG_W  = 4,
  parameter int ADDR_W = 1
) (
  input  logic              softRst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic              evRemote,
  input  logic              evStore,
  input  logic              evTxDone,
  input  slotState_t        st,
  output slotStrobe_t       stb
);
  logic wrCtrl;
  logic wrCfg;
  logic storeHit;

  always_comb begin
    wrCtrl   = wrEn && (wrAddr == ADDR_W'(CTRL_ADDR));
    wrCfg    = wrEn && (wrAddr == ADDR_W'(CFG_ADDR));
    // a receive slot drops a store when overwrites are off and data is unread
    storeHit = evStore && !st.dir && !(st.fresh && !st.ovEn);

    stb.loadCfg   = wrCfg;
    stb.dirVal    = wrData[DIR_BIT];
    stb.ovEnVal   = wrData[OVEN_BIT];

    stb.loadFresh = wrCtrl || storeHit;
    stb.freshVal  = storeHit ? 1'b1 : wrData[FRESH_BIT];
    stb.setOvr    = storeHit && st.fresh;
    stb.clrOvr    = wrCtrl && !wrData[FRESH_BIT];

    stb.loadInh   = wrCtrl && st.dir;
    stb.inhVal    = wrData[SHARE_BIT];

    stb.killHreq  = softRst;
    stb.setHreq   = (wrCtrl && wrData[HREQ_BIT]) || (evRemote && st.dir);
    stb.clrHreq   = evTxDone;

    stb.setXreq   = evRemote;
    stb.clrXreq   = (evTxDone && st.dir) || (wrCtrl && !wrData[XREQ_BIT]);
  end
endmodule

// File: rtl/can_slot_dp.sv
module can_slot_dp
  import can_slot_pkg::*;
#(
  parameter int REG_W  = 4,
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  slotStrobe_t       stb,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData,
  output slotState_t        st,
  output logic              sendData,
  output logic              sendRemote
);
  localparam int PAD_W = REG_W - 4;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= '0;
    end else begin
      if (stb.loadCfg) begin
        st.dir  <= stb.dirVal;
        st.ovEn <= stb.ovEnVal;
      end
      if (stb.loadFresh) st.fresh <= stb.freshVal;
      if (stb.setOvr)      st.ovr <= 1'b1;
      else if (stb.clrOvr) st.ovr <= 1'b0;
      if (stb.loadInh) st.inh <= stb.inhVal;
      if (stb.killHreq)     st.hreq <= 1'b0;
      else if (stb.setHreq) st.hreq <= 1'b1;
      else if (stb.clrHreq) st.hreq <= 1'b0;
      if (stb.setXreq)      st.xreq <= 1'b1;
      else if (stb.clrXreq) st.xreq <= 1'b0;
    end
  end

  logic shareBit;
  logic [3:0] ctrlView;
  logic [3:0] cfgView;

  always_comb begin
    // a stale inhibit leaks through in receive mode when overwrites are enabled
    shareBit = st.dir ? st.inh : (st.ovr || (st.inh && st.ovEn));
    ctrlView = '0;
    ctrlView[FRESH_BIT] = st.fresh;
    ctrlView[SHARE_BIT] = shareBit;
    ctrlView[HREQ_BIT]  = st.hreq;
    ctrlView[XREQ_BIT]  = st.xreq;
    cfgView = '0;
    cfgView[DIR_BIT]  = st.dir;
    cfgView[OVEN_BIT] = st.ovEn;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign rdData = (rdAddr == ADDR_W'(CFG_ADDR)) ? {{PAD_W{1'b0}}, cfgView}
                                                     : {{PAD_W{1'b0}}, ctrlView};
    end else begin : g_nopad
      assign rdData = (rdAddr == ADDR_W'(CFG_ADDR)) ? cfgView : ctrlView;
    end
  endgenerate

  assign sendData   = st.dir && st.hreq && !st.inh && (!st.xreq || st.fresh);
  assign sendRemote = !st.dir && st.hreq;
endmodule

// File: rtl/can_slot_req_ctrl.sv
module can_slot_req_ctrl
  import can_slot_pkg::*;
#(
  parameter int REG_W  = 4,
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData,
  input  logic              evRemote,
  input  logic              evStore,
  input  logic              evTxDone,
  output logic              sendData,
  output logic              sendRemote
);
  slotStrobe_t slotStb;
  slotState_t  slotSt;

  can_slot_ctrl #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_ctrl (
    .softRst(softRst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .evRemote(evRemote), .evStore(evStore), .evTxDone(evTxDone),
    .st(slotSt), .stb(slotStb)
  );

  can_slot_dp #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(slotStb), .rdAddr(rdAddr), .rdData(rdData),
    .st(slotSt), .sendData(sendData), .sendRemote(sendRemote)
  );
endmodule

// File: rtl/can_slot_req_chk.sv
module can_slot_req_chk
  import can_slot_pkg::*;
#(
  parameter int REG_W  = 4,
  parameter int ADDR_W = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              softRst,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [REG_W-1:0]  wrData,
  input logic              evRemote,
  input logic              evStore,
  input logic              evTxDone,
  input logic              sendData,
  input logic              sendRemote,
  input slotState_t        st
);
  logic ctrlWr;
  assign ctrlWr = wrEn && (wrAddr == ADDR_W'(CTRL_ADDR));

  // R2
  remote_sets_xreq_chk: assert property (@(posedge clk) disable iff (!rstN)
    evRemote |=> st.xreq);
  // R3
  data_needs_clear_inhibit_chk: assert property (@(posedge clk) disable iff (!rstN)
    sendData |-> (st.dir && !st.inh && (!st.xreq || st.fresh)));
  // R4
  done_clears_xreq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.dir && evTxDone && !evRemote) |=> !st.xreq);
  // R5
  hreq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.hreq && !softRst && !evTxDone) |=> st.hreq);
  // R6
  soft_clears_hreq_chk: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> !st.hreq);
  // R7
  remote_send_rx_chk: assert property (@(posedge clk) disable iff (!rstN)
    sendRemote |-> (!st.dir && st.hreq));
  // R10
  store_dropped_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evStore && !st.dir && st.fresh && !st.ovEn && !st.ovr && !wrEn) |=> !st.ovr);
  // R13
  write_beats_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && wrData[HREQ_BIT] && !softRst) |=> st.hreq);
endmodule

bind can_slot_req_ctrl can_slot_req_chk #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .softRst(softRst), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrData(wrData), .evRemote(evRemote), .evStore(evStore), .evTxDone(evTxDone),
  .sendData(sendData), .sendRemote(sendRemote), .st(slotSt)
);

// File: tb/sim_can_slot_req_ctrl.sv
module sim_can_slot_req_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic softRst = 1'b0;
  logic wrEn = 1'b0;
  logic [0:0] wrAddr = '0;
  logic [3:0] wrData = '0;
  logic [0:0] rdAddr = '0;
  logic [3:0] rdData;
  logic evRemote = 1'b0;
  logic evStore = 1'b0;
  logic evTxDone = 1'b0;
  logic sendData;
  logic sendRemote;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  can_slot_req_ctrl #(.REG_W(4), .ADDR_W(1)) u0 (
    .clk(clk), .rstN(rstN), .softRst(softRst), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .evRemote(evRemote),
    .evStore(evStore), .evTxDone(evTxDone), .sendData(sendData),
    .sendRemote(sendRemote)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // one clock of stimulus, starting and ending on a falling edge
  task automatic cyc(input logic w, input logic a, input logic [3:0] d,
                     input logic rem, input logic sto, input logic don, input logic sr);
    wrEn = w; wrAddr = a; wrData = d;
    evRemote = rem; evStore = sto; evTxDone = don; softRst = sr;
    @(posedge clk);
    @(negedge clk);
    wrEn = 0; evRemote = 0; evStore = 0; evTxDone = 0; softRst = 0;
  endtask

  task automatic wr(input logic a, input logic [3:0] d);
    cyc(1, a, d, 0, 0, 0, 0);
  endtask

  task automatic rdChk(input string req, input logic a, input logic [3:0] exp);
    rdAddr = a;
    #1;
    chk(req, rdData, exp);
  endtask

  task automatic tReset();
    rdChk("R1 ctrl", 0, 4'b0000);
    rdChk("R1 cfg", 1, 4'b0000);
    chk("R1 send", {2'b0, sendData, sendRemote}, 4'b0000);
  endtask

  task automatic tRxRemote();
    wr(1, 4'b0000);
    cyc(0, 0, 0, 1, 0, 0, 0);
    rdChk("R2 rx remote", 0, 4'b1000);
    cyc(0, 0, 0, 0, 0, 1, 0);
    rdChk("R4 rx done keeps ext", 0, 4'b1000);
    wr(0, 4'b0000);
    rdChk("R4 host clears ext", 0, 4'b0000);
  endtask

  task automatic tRxHostReq();
    wr(0, 4'b0100);
    rdChk("R5 set hreq", 0, 4'b0100);
    chk("R7 rx remote send", {2'b0, sendData, sendRemote}, 4'b0001);
    wr(0, 4'b0000);
    rdChk("R5 write0 no effect", 0, 4'b0100);
    cyc(1, 0, 4'b0100, 0, 0, 0, 1);
    rdChk("R6 soft reset wins", 0, 4'b0000);
    wr(0, 4'b0100);
    cyc(0, 0, 0, 0, 0, 1, 0);
    rdChk("R4 rx done clears hreq", 0, 4'b0000);
    chk("R4 rx send off", {2'b0, sendData, sendRemote}, 4'b0000);
  endtask

  task automatic tStore();
    wr(1, 4'b0010);
    cyc(0, 0, 0, 0, 1, 0, 0);
    rdChk("R8 first store", 0, 4'b0001);
    cyc(0, 0, 0, 0, 1, 0, 0);
    rdChk("R8 overwrite", 0, 4'b0011);
    wr(0, 4'b0000);
    rdChk("R9 clear fresh", 0, 4'b0000);
    wr(1, 4'b0000);
    cyc(0, 0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 0);
    rdChk("R10 store dropped", 0, 4'b0001);
    wr(0, 4'b0000);
    wr(1, 4'b0001);
    cyc(0, 0, 0, 0, 1, 0, 0);
    rdChk("R8 tx store ignored", 0, 4'b0000);
  endtask

  task automatic tTxRemote();
    wr(0, 4'b0010);
    cyc(0, 0, 0, 1, 0, 0, 0);
    rdChk("R11 remote while inhibited", 0, 4'b1110);
    chk("R11 inhibited no send", {3'b0, sendData}, 4'b0000);
    wr(0, 4'b1000);
    rdChk("R3 stale data", 0, 4'b1100);
    chk("R3 stale no send", {3'b0, sendData}, 4'b0000);
    wr(0, 4'b1001);
    rdChk("R11 release", 0, 4'b1101);
    chk("R3 fresh sends", {3'b0, sendData}, 4'b0001);
    cyc(0, 0, 0, 0, 0, 1, 0);
    rdChk("R4 tx done clears", 0, 4'b0001);
    chk("R4 tx send off", {3'b0, sendData}, 4'b0000);
  endtask

  task automatic tTxHostReq();
    wr(0, 4'b0100);
    chk("R7 tx data send", {2'b0, sendData, sendRemote}, 4'b0010);
    cyc(1, 0, 4'b0100, 0, 0, 1, 0);
    rdChk("R13 write beats done", 0, 4'b0100);
    cyc(0, 0, 0, 0, 0, 1, 0);
    rdChk("R13 done alone clears", 0, 4'b0000);
  endtask

  task automatic tShared();
    wr(1, 4'b0000);
    wr(0, 4'b0010);
    rdChk("R11 rx inhibit write blocked", 0, 4'b0000);
    wr(1, 4'b0001);
    wr(0, 4'b0010);
    wr(1, 4'b0011);
    rdChk("R12 tx inhibit reads", 0, 4'b0010);
    wr(1, 4'b0010);
    rdChk("R12 stale inhibit leaks", 0, 4'b0010);
    wr(1, 4'b0000);
    rdChk("R12 ovr enable off", 0, 4'b0000);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tRxRemote();
    tRxHostReq();
    tStore();
    wr(0, 4'b0000);
    wr(1, 4'b0001);
    tTxRemote();
    wr(0, 4'b0000);
    tTxHostReq();
    tShared();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule